// File: doc/BRIEF.md
# Pin Interrupt Dispatcher with End-of-Interrupt Handshake

This block stands behind a table of redirection entries and turns pin activity into delivery messages for the interrupt fabric. Each pin owns a signed up/down counter. Assert commands raise it, deassert commands lower it, and a pulse acts as a back-to-back assert and deassert. Several sources that share one pin therefore merge. A delivery attempt is made only when an assert takes the counter from zero to one.

An attempt is dropped when the pin is masked. For a level-triggered pin the attempt is held back while the pin's remote-IRR flag is set. If the flag is clear, the attempt sets it. An end-of-interrupt notification carries a vector. It clears remote-IRR on every pin whose flag is set and whose entry holds that vector, and it redelivers any such pin whose source is still held. A rewrite of an entry also re-evaluates the pin: a held level pin tries again, and a pin changed to edge mode loses its remote-IRR flag.

Attempts that pass these checks become bits in a request bitmap. The bitmap drains through a valid/ready port, lowest pin first, one pin per handshake. The message fields are read from the entry at the moment of sending. The entry storage and the register decode that fills it lie outside this block; the remote-IRR flags are returned to that storage for read-back.

Top module: `irqd_dispatch`

## Requirements
- R1: After reset no delivery is offered, every remote-IRR flag is 0 and the error output is 0.
- R2: An assert on a pin whose counter is 0 produces one delivery attempt. A further assert on a pin already held (counter above 0) produces none. A request appears on the delivery port in the cycle after the command.
- R3: A pulse behaves as an assert followed at once by a deassert. It attempts delivery when the counter is 0 and leaves the counter unchanged.
- R4: A command whose pin number (a 6-bit field) is 32 or more changes no state and produces no delivery.
- R5: An attempt on a pin whose mask bit (entry bit 16) is 1 is dropped and leaves nothing pending.
- R6: For a level-triggered pin (entry bit 15 = 1), an attempt sets remote-IRR and is sent. An attempt made while remote-IRR is already set is suppressed.
- R7: An end-of-interrupt with vector V clears remote-IRR on every pin whose remote-IRR is set and whose entry vector (bits 7:0) equals V. Each such pin whose counter is above 0 gets a new attempt.
- R8: On a write of a pin's entry, an edge-mode result (bit 15 = 0) clears remote-IRR, and a level-mode result with counter above 0 gets a new attempt.
- R9: The message carries vector = entry[7:0], delivery mode = entry[10:8], logical-destination flag = entry[11], trigger flag = entry[15] and destination = entry[63:56], all taken from the entry of the pin being offered.
- R10: Pending pins are offered lowest pin number first. A pending pin stays offered until the handshake (valid and ready high together) takes it, and each handshake takes exactly one pin.
- R11: A deassert that takes a counter below 0 sets the error output one cycle later. The error output stays set until reset, and a counter at or below 0 never causes a delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Pin command strobe |
| cmd_op | input | 2 | 0 none, 1 assert, 2 deassert, 3 pulse |
| cmd_pin | input | 6 | Target pin of the command |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| entry_wr_valid | input | 1 | Strobe: an entry has just been rewritten |
| entry_wr_pin | input | 5 | Pin whose entry was rewritten |
| entry_flat | input | 2048 | All 32 entries of 64 bits, pin i at bits 64*i+63 down to 64*i |
| dlv_ready | input | 1 | Fabric accepts the offered message |
| dlv_valid | output | 1 | A message is offered |
| dlv_vector | output | 8 | Message vector |
| dlv_dest | output | 8 | Message destination |
| dlv_logical | output | 1 | 1 = logical destination, 0 = physical |
| dlv_mode | output | 3 | Delivery mode |
| dlv_level | output | 1 | 1 = level-triggered |
| irr_o | output | 32 | Remote-IRR flag per pin |
| err_o | output | 1 | Sticky flag: a counter went negative |

## Verification
The hardest state to reach from the ports is a level pin whose source is still held while its remote-IRR is set. That state is needed to show that an end-of-interrupt or an entry rewrite redelivers the pin, and that a second rising edge on the pin stays silent. The directed part builds it in order: configure the pin for level mode, assert it, let the message go, then deassert and reassert. Next an end-of-interrupt is sent, followed by a rewrite of the same entry, a switch to edge mode and a switch back. A random phase follows. It draws vectors from a small set so that one end-of-interrupt hits several pins, and it leaves the ready signal low for stretches so that requests pile up in the bitmap.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ENTRY_W   = 64;
  localparam int VEC_LSB   = 0;
  localparam int VEC_W     = 8;
  localparam int MODE_LSB  = 8;
  localparam int MODE_W    = 3;
  localparam int LOGIC_BIT = 11;
  localparam int LEVEL_BIT = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;
  localparam int DEST_W    = 8;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_ASSERT   = 2'd1,
    OP_DEASSERT = 2'd2,
    OP_PULSE    = 2'd3
  } pin_op_e;
endpackage

// File: rtl/irqd_pin_slot.sv
module irqd_pin_slot
  import irqd_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_hit,
  input  logic [1:0] cmd_op,
  input  logic       eoi_hit,
  input  logic       wr_hit,
  input  logic       lvl_i,
  input  logic       msk_i,
  input  logic       grant_i,
  output logic       req_o,
  output logic       irr_o,
  output logic       neg_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic irr_q, irr_d, req_q, req_d;
  logic try_cmd, held, eoi_clr, wr_edge, try_eoi, try_wr, irr_keep, fire, upd_en;

  always_comb begin
    cnt_d   = cnt_q;
    try_cmd = 1'b0;
    if (cmd_hit) begin
      case (pin_op_e'(cmd_op))
        OP_ASSERT: begin
          if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
          try_cmd = (cnt_q == '0);
        end
        OP_DEASSERT: begin
          if (cnt_q != CNT_MIN) cnt_d = cnt_q - CNT_W'(1);
        end
        OP_PULSE: try_cmd = (cnt_q == '0);
        default: ;
      endcase
    end
    held     = !cnt_q[CNT_W-1] && (cnt_q != '0);
    eoi_clr  = eoi_hit && irr_q;
    wr_edge  = wr_hit && !lvl_i;
    try_eoi  = eoi_clr && held;
    try_wr   = wr_hit && lvl_i && held;
    irr_keep = irr_q && !eoi_clr && !wr_edge;
    fire     = (try_cmd || try_eoi || try_wr) && !msk_i && !(lvl_i && irr_keep);
    irr_d    = irr_keep || (fire && lvl_i);
    req_d    = (req_q && !grant_i) || fire;
    upd_en   = cmd_hit || eoi_hit || wr_hit || grant_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irr_q <= 1'b0;
      req_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      irr_q <= irr_d;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;
  assign irr_o = irr_q;
  assign neg_o = cnt_q[CNT_W-1];

  // R5: a new request only follows an unmasked attempt
  p_mask_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(!msk_i));
  // R6: remote-IRR is only raised for a level pin
  p_irr_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irr_q) |-> $past(lvl_i));
  // R11: a counter at or below zero never fires through eoi or rewrite
  p_neg_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_o && !cmd_hit) |-> !fire);
endmodule

// File: rtl/irqd_prio_pick.sv
module irqd_prio_pick #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]     = req_i[i] && !blocked[i];
    assign blocked[i+1] = blocked[i] || req_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  assign any_o = blocked[N];
endmodule

// File: rtl/irqd_dispatch.sv
module irqd_dispatch
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int CNT_W    = 6,
  parameter int IDX_W    = $clog2(NUM_PINS),
  parameter int PIN_W    = IDX_W + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [PIN_W-1:0]             cmd_pin,
  input  logic                         eoi_valid,
  input  logic [VEC_W-1:0]             eoi_vector,
  input  logic                         entry_wr_valid,
  input  logic [IDX_W-1:0]             entry_wr_pin,
  input  logic [NUM_PINS*ENTRY_W-1:0]  entry_flat,
  input  logic                         dlv_ready,
  output logic                         dlv_valid,
  output logic [VEC_W-1:0]             dlv_vector,
  output logic [DEST_W-1:0]            dlv_dest,
  output logic                         dlv_logical,
  output logic [MODE_W-1:0]            dlv_mode,
  output logic                         dlv_level,
  output logic [NUM_PINS-1:0]          irr_o,
  output logic                         err_o
);
  logic [NUM_PINS-1:0] req, gnt_oh, grant, neg;
  logic [IDX_W-1:0]    pick_idx;
  logic [ENTRY_W-1:0]  sel_entry;
  logic                err_q, err_d;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [ENTRY_W-1:0] ent;
    logic cmd_hit, eoi_hit, wr_hit;
    assign ent     = entry_flat[i*ENTRY_W +: ENTRY_W];
    assign cmd_hit = cmd_valid && (cmd_pin == PIN_W'(i));
    assign eoi_hit = eoi_valid && (ent[VEC_LSB +: VEC_W] == eoi_vector);
    assign wr_hit  = entry_wr_valid && (entry_wr_pin == IDX_W'(i));

    irqd_pin_slot #(.CNT_W(CNT_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_hit (cmd_hit),
      .cmd_op  (cmd_op),
      .eoi_hit (eoi_hit),
      .wr_hit  (wr_hit),
      .lvl_i   (ent[LEVEL_BIT]),
      .msk_i   (ent[MASK_BIT]),
      .grant_i (grant[i]),
      .req_o   (req[i]),
      .irr_o   (irr_o[i]),
      .neg_o   (neg[i])
    );
  end

  irqd_prio_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .req_i (req),
    .gnt_o (gnt_oh),
    .idx_o (pick_idx),
    .any_o (dlv_valid)
  );

  assign grant     = gnt_oh & {NUM_PINS{dlv_ready}};
  assign sel_entry = entry_flat[pick_idx*ENTRY_W +: ENTRY_W];

  assign dlv_vector  = sel_entry[VEC_LSB +: VEC_W];
  assign dlv_dest    = sel_entry[DEST_LSB +: DEST_W];
  assign dlv_logical = sel_entry[LOGIC_BIT];
  assign dlv_mode    = sel_entry[MODE_LSB +: MODE_W];
  assign dlv_level   = sel_entry[LEVEL_BIT];

  always_comb err_d = err_q || (|neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (|neg)   err_q <= err_d;
  end

  assign err_o = err_q;

  // R10: at most one pin is taken per handshake
  p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R10: an offer not accepted stays offered
  p_offer_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> dlv_valid);
  // R11: the error flag never drops once raised
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

// File: tb/tb_irqd_dispatch.sv
module tb_irqd_dispatch;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [5:0] cmd_pin = '0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic entry_wr_valid = 1'b0;
  logic [4:0] entry_wr_pin = '0;
  logic [N*64-1:0] entry_flat;
  logic dlv_ready = 1'b1;
  logic dlv_valid, dlv_logical, dlv_level, err_o;
  logic [7:0] dlv_vector, dlv_dest;
  logic [2:0] dlv_mode;
  logic [N-1:0] irr_o;

  logic [63:0] ent [N];
  int  m_cnt [N];
  bit  m_irr [N];
  bit  m_req [N];
  bit  m_err;
  int  n_chk = 0, n_bad = 0, n_del = 0;
  logic [7:0] last_vec;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) entry_flat[i*64 +: 64] = ent[i];

  irqd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pin(cmd_pin),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .entry_wr_valid(entry_wr_valid),
    .entry_wr_pin(entry_wr_pin), .entry_flat(entry_flat), .dlv_ready(dlv_ready),
    .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
    .dlv_logical(dlv_logical), .dlv_mode(dlv_mode), .dlv_level(dlv_level),
    .irr_o(irr_o), .err_o(err_o)
  );

  function automatic logic [63:0] mk_ent(logic [7:0] vec, logic [7:0] dst, logic [2:0] mode,
                                         logic lgc, logic lvl, logic msk);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = mode; e[11] = lgc; e[15] = lvl; e[16] = msk; e[63:56] = dst;
    return e;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference model: one clock edge of the dispatcher per the requirements
  task automatic model_edge();
    int lo = -1;
    bit neg_any = 1'b0;
    for (int i = 0; i < N; i++) if (m_req[i] && lo < 0) lo = i;
    for (int i = 0; i < N; i++) if (m_cnt[i] < 0) neg_any = 1'b1;
    if (neg_any) m_err = 1'b1;
    for (int i = 0; i < N; i++) begin
      bit held = (m_cnt[i] > 0);
      bit lvl = ent[i][15];
      bit msk = ent[i][16];
      bit tr = 1'b0;
      bit keep, fire;
      bit eclr = eoi_valid && m_irr[i] && (ent[i][7:0] == eoi_vector);
      bit wr = entry_wr_valid && (entry_wr_pin == 5'(i));
      if (cmd_valid && cmd_pin == 6'(i)) begin
        if (cmd_op == 2'd1) begin tr = (m_cnt[i] == 0); m_cnt[i]++; end
        else if (cmd_op == 2'd2) m_cnt[i]--;
        else if (cmd_op == 2'd3) tr = (m_cnt[i] == 0);
      end
      if (eclr && held) tr = 1'b1;
      if (wr && lvl && held) tr = 1'b1;
      keep = m_irr[i] && !eclr && !(wr && !lvl);
      fire = tr && !msk && !(lvl && keep);
      m_irr[i] = keep || (fire && lvl);
      m_req[i] = (m_req[i] && !(lo == i && dlv_ready)) || fire;
    end
  endtask

  task automatic compare();
    int lo = -1;
    logic [N-1:0] exp_irr;
    for (int i = 0; i < N; i++) begin
      exp_irr[i] = m_irr[i];
      if (m_req[i] && lo < 0) lo = i;
    end
    check("R10 valid", 64'(dlv_valid), 64'(lo >= 0));
    if (lo >= 0) begin
      check("R9 vector", 64'(dlv_vector), 64'(ent[lo][7:0]));
      check("R9 dest", 64'(dlv_dest), 64'(ent[lo][63:56]));
      check("R9 mode", 64'({dlv_logical, dlv_mode, dlv_level}),
            64'({ent[lo][11], ent[lo][10:8], ent[lo][15]}));
    end
    check("R6 irr", 64'(irr_o), 64'(exp_irr));
    check("R11 err", 64'(err_o), 64'(m_err));
  endtask

  task automatic tick();
    bit hs;
    #1;
    hs = dlv_valid && dlv_ready;
    if (hs) last_vec = dlv_vector;
    @(posedge clk);
    if (rst_n) model_edge();
    if (hs) n_del++;
    @(negedge clk);
    compare();
    cmd_valid = 1'b0; eoi_valid = 1'b0; entry_wr_valid = 1'b0;
  endtask

  task automatic do_cmd(logic [1:0] op, int pin);
    cmd_valid = 1'b1; cmd_op = op; cmd_pin = 6'(pin); tick();
  endtask
  task automatic do_eoi(logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v; tick();
  endtask
  task automatic do_wr(int pin, logic [63:0] val);
    ent[pin] = val; entry_wr_valid = 1'b1; entry_wr_pin = 5'(pin); tick();
  endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int n0;
    for (int i = 0; i < N; i++) begin
      ent[i] = mk_ent(8'(8'h40 + i), 8'(i * 3), 3'(i), i[0], 1'b0, 1'b1);
      m_cnt[i] = 0; m_irr[i] = 1'b0; m_req[i] = 1'b0;
    end
    m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 valid", 64'(dlv_valid), 0);
    check("R1 irr", 64'(irr_o), 0);
    check("R1 err", 64'(err_o), 0);

    // R5: masked pin drops its attempt
    do_cmd(2'd1, 2); idle(2);
    check("R5 no delivery", 64'(n_del), 0);
    check("R5 no offer", 64'(dlv_valid), 0);
    do_cmd(2'd2, 2);

    for (int i = 0; i < 16; i++)
      do_wr(i, mk_ent(8'(8'h40 + i), 8'(i * 3), 3'(i), i[0], 1'b0, 1'b0));

    // R2: only the 0->1 assert fires
    do_cmd(2'd1, 4);
    check("R2 offer next cycle", 64'(dlv_valid), 1);
    do_cmd(2'd1, 4); idle(2);
    check("R2 one delivery", 64'(n_del), 1);
    check("R2 vector", 64'(last_vec), 64'h44);

    // R3: pulse fires at count 0, not on a held pin
    do_cmd(2'd3, 5); idle(2);
    check("R3 pulse delivers", 64'(n_del), 2);
    do_cmd(2'd3, 5); idle(2);
    check("R3 second pulse", 64'(n_del), 3);
    do_cmd(2'd3, 4); idle(2);
    check("R3 pulse on held pin", 64'(n_del), 3);

    // R4: out-of-range pin ignored
    do_cmd(2'd1, 40); idle(2);
    check("R4 no offer", 64'(dlv_valid), 0);
    check("R4 no delivery", 64'(n_del), 3);

    // R10: ascending order, held while not ready
    dlv_ready = 1'b0;
    do_cmd(2'd1, 7); do_cmd(2'd1, 1); do_cmd(2'd1, 6); idle(2);
    check("R10 lowest offered", 64'(dlv_vector), 64'h41);
    dlv_ready = 1'b1;
    tick(); check("R10 first", 64'(last_vec), 64'h41);
    tick(); check("R10 second", 64'(last_vec), 64'h46);
    tick(); check("R10 third", 64'(last_vec), 64'h47);
    idle(1);
    check("R10 drained", 64'(dlv_valid), 0);

    // R6: level pin and remote-IRR
    do_wr(9, mk_ent(8'h60, 8'h99, 3'd1, 1'b0, 1'b1, 1'b0));
    do_cmd(2'd1, 9); idle(2);
    check("R6 irr set", 64'(irr_o[9]), 1);
    check("R6 level flag sent", 64'(last_vec), 64'h60);
    n0 = n_del;
    do_cmd(2'd2, 9); do_cmd(2'd1, 9); idle(2);
    check("R6 suppressed", 64'(n_del), 64'(n0));

    // R7: EOI clears and redelivers a held pin
    do_eoi(8'h60); idle(2);
    check("R7 redelivered", 64'(n_del), 64'(n0 + 1));
    check("R7 irr again", 64'(irr_o[9]), 1);

    // R8: entry rewrites
    n0 = n_del;
    do_wr(9, mk_ent(8'h60, 8'h99, 3'd1, 1'b0, 1'b1, 1'b0)); idle(2);
    check("R8 rewrite with irr set", 64'(n_del), 64'(n0));
    do_wr(9, mk_ent(8'h60, 8'h99, 3'd1, 1'b0, 1'b0, 1'b0)); idle(1);
    check("R8 edge clears irr", 64'(irr_o[9]), 0);
    check("R8 edge no attempt", 64'(n_del), 64'(n0));
    do_wr(9, mk_ent(8'h60, 8'h99, 3'd1, 1'b0, 1'b1, 1'b0)); idle(2);
    check("R8 level rewrite delivers", 64'(n_del), 64'(n0 + 1));
    check("R8 irr set", 64'(irr_o[9]), 1);
    do_cmd(2'd2, 9); do_eoi(8'h60);

    // Random phase (fields R9, order R10, irr R6, err R11 checked each cycle)
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      int p = $urandom % 40;
      int op = $urandom % 4;
      dlv_ready = ($urandom % 10) < 7;
      if (op == 2 && (p >= N || m_cnt[p] <= 0)) op = 3;
      if ($urandom % 3 != 0) begin
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_pin = 6'(p);
      end
      if ($urandom % 6 == 0) begin
        eoi_valid = 1'b1; eoi_vector = 8'(8'h40 + ($urandom % 8));
      end
      if ($urandom % 8 == 0) begin
        int q = $urandom % N;
        ent[q] = mk_ent(8'(8'h40 + ($urandom % 8)), 8'($urandom), 3'($urandom),
                        1'($urandom), 1'($urandom), ($urandom % 4) == 0);
        entry_wr_valid = 1'b1; entry_wr_pin = 5'(q);
      end
      tick();
    end
    dlv_ready = 1'b1;
    idle(40);

    // R11: negative counter flags error and never fires
    ent[12] = mk_ent(8'h70, 8'h12, 3'd0, 1'b0, 1'b0, 1'b0);
    while (m_cnt[12] > 0) do_cmd(2'd2, 12);
    idle(4);
    n0 = n_del;
    do_cmd(2'd2, 12); idle(1);
    check("R11 err set", 64'(err_o), 1);
    do_cmd(2'd1, 12); idle(2);
    check("R11 no delivery from negative", 64'(n_del), 64'(n0));
    summary();
  end
endmodule